// File: doc/BRIEF.md
# Tagless FFT Frame Cache Controller

This controller shuttles one frame of complex samples between a large, slow processor RAM and a small on-chip cache that feeds a butterfly datapath. Each sample is a pair of 32-bit words, the real part first and the imaginary part second. A frame of up to 64 points therefore takes 128 RAM words. A short configuration word, sampled when a frame is started, selects the transform direction and the number of points.

The cache has no tags and produces no hit or miss signal. The access order never depends on the data, so every cache slot is tied to one RAM sample by a fixed bit-reversal of the sample index, taken over the active length. The whole frame is loaded into the cache before the datapath sees its first sample. The datapath then reads slots in ascending order and writes its results into slots that it has already consumed. At the end the cache is emptied back into RAM through the inverse of the same mapping. The RAM side is paced by a clock-enable strobe, and one RAM word moves per enabled cycle.

Top module: `fft_frame_cache`

## Requirements
- R1: `cfg[2:0]` is the length code. Codes 1 to 6 select 2^code points (2, 4, 8, 16, 32, 64), and an accepted frame reads and writes exactly 2·2^code RAM words.
- R2: A start that carries code 0 or 7 sets `err` to 1 and leaves the block idle: no RAM access, no datapath traffic and no `done`. The next accepted start clears `err` to 0.
- R3: `dir` takes `cfg[3]` (0 forward, 1 inverse) when a start is accepted and holds that value until the next accepted start.
- R4: In prefetch, RAM words are read at addresses 0, 1, …, 2L−1 in that order. Word 2i is the real part of sample i and word 2i+1 its imaginary part. One word is accessed per cycle with `ram_ce` high, and none with `ram_ce` low.
- R5: The k-th sample presented on the read port (k = 0…L−1) is RAM sample bitrev(k), with the bits reversed over log2(L) bits. `rd_valid` rises only after all 2L words of the prefetch have been read.
- R6: While `rd_valid` is high and `rd_ready` is low, `rd_valid`, `rd_re` and `rd_im` hold. `wr_ready` is high only while fewer results have been accepted than samples have been read.
- R7: In write-back, RAM word 2i receives the real part and word 2i+1 the imaginary part of the result accepted at position bitrev(i). Words are written in ascending address order, and only in cycles with `ram_ce` high.
- R8: `done` is a one-cycle pulse after the last write-back word. The block is idle in the following cycle.
- R9: A start raised while a frame is in progress is ignored. Neither the length nor `dir` of the running frame changes.
- R10: After reset the block is idle, with `done`, `err`, `dir`, `ram_en`, `ram_we`, `rd_valid` and `wr_ready` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the RAM side and the cache side |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a frame; taken only when idle |
| cfg | input | 4 | Bit 3 is the direction, bits 2:0 the length code |
| err | output | 1 | Last start carried an illegal length code |
| dir | output | 1 | Direction of the current frame, passed to the datapath |
| done | output | 1 | One-cycle pulse when the frame is back in RAM |
| ram_ce | input | 1 | RAM-side pacing strobe |
| ram_en | output | 1 | RAM access this cycle |
| ram_we | output | 1 | RAM write this cycle |
| ram_addr | output | 7 | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, valid in the same cycle as the address |
| rd_valid | output | 1 | A sample is offered to the datapath |
| rd_ready | input | 1 | Datapath takes the offered sample |
| rd_re | output | 32 | Real part of the offered sample |
| rd_im | output | 32 | Imaginary part of the offered sample |
| wr_valid | input | 1 | Datapath offers a result |
| wr_ready | output | 1 | Controller accepts the offered result |
| wr_re | input | 32 | Real part of the result |
| wr_im | input | 32 | Imaginary part of the result |

## Verification
The bench builds the block with its default parameters: a 64-point maximum, 32-bit words and a 4-bit configuration word. These defaults bring the full-length bit-reversal within reach, along with the 128-word address range and code 7 as an illegal code above the maximum. Frames of 2, 8, 16, 32 and 64 points are run under different RAM strobe rates and datapath ready patterns. These frames exercise stalls on both handshake directions, the write-after-read gate and a start raised in the middle of a frame.

// File: rtl/fftc_pkg.sv
// Shared types and the index map for the tagless frame cache.
// Assumes a maximum length exponent of at most 7.
package fftc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREFETCH,
        ST_RUN,
        ST_WBACK,
        ST_DONE
    } fftc_state_t;

    // Reverse the low lg bits of v; the upper bits come out zero.
    function automatic logic [7:0] rev_low(input logic [7:0] v, input logic [2:0] lg);
        logic [7:0] r;
        r = '0;
        for (int b = 0; b < 8; b++) begin
            if (b < int'(lg)) r[b] = v[int'(lg) - 1 - b];
        end
        return r;
    endfunction

endpackage

// File: rtl/fftc_cfg_decode.sv
// Splits the configuration word into a direction bit and a length exponent,
// and flags length codes outside 1..LG_MAX as illegal.
// Assumes the length code sits in the three low bits and the direction in the MSB.
module fftc_cfg_decode #(
    parameter int CFG_W  = 4,
    parameter int LG_MAX = 6
) (
    input  logic [CFG_W-1:0] cfg,
    output logic             legal,
    output logic [2:0]       lg,
    output logic             inv
);
    // Field split and legality test.
    always_comb begin
        lg    = cfg[2:0];
        inv   = cfg[CFG_W-1];
        legal = (cfg[2:0] != 3'd0) && (int'(cfg[2:0]) <= LG_MAX);
    end
endmodule

// File: rtl/fftc_agu.sv
// Address generator for the RAM-side phases. It steps a word counter once per
// strobe, derives the sample part (real or imaginary) and the bit-reversed cache
// slot, and flags the last word of the active length. It is held at zero while
// not running.
module fftc_agu #(
    parameter int LG_MAX = 6,
    localparam int PW    = LG_MAX + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              step,
    input  logic [2:0]        lg,
    output logic [PW-1:0]     word,
    output logic [LG_MAX-1:0] slot,
    output logic              part,
    output logic              last
);
    import fftc_pkg::*;

    logic [PW:0] span;

    // Word counter, cleared outside the RAM phases.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) word <= '0;
        else if (step)      word <= word + PW'(1);
    end

    // Slot map and end-of-frame detection.
    always_comb begin
        logic [7:0] r;
        span = ((PW + 1)'(2) << lg) - (PW + 1)'(1);
        last = ({1'b0, word} == span);
        part = word[0];
        r    = rev_low(8'(word[PW-1:1]), lg);
        slot = r[LG_MAX-1:0];
    end
endmodule

// File: rtl/fftc_cache_buf.sv
// Cache store with one lane per complex part: a shared write port with a
// write enable per lane, and two combinational read ports.
// Assumes no simultaneous writes from different sources (the sequencer muxes them).
module fftc_cache_buf #(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic                 clk,
    input  logic [1:0]           we,
    input  logic [AW-1:0]        waddr,
    input  logic [1:0][DW-1:0]   wdata,
    input  logic [AW-1:0]        ra,
    input  logic [AW-1:0]        rb,
    output logic [1:0][DW-1:0]   qa,
    output logic [1:0][DW-1:0]   qb
);
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [DW-1:0] mem [2**AW];

        // Lane storage write.
        always_ff @(posedge clk) begin
            if (we[g]) mem[waddr] <= wdata[g];
        end

        assign qa[g] = mem[ra];
        assign qb[g] = mem[rb];
    end
endmodule

// File: rtl/fft_frame_cache.sv
// Tagless frame cache controller. It prefetches one frame from RAM into the
// cache with a bit-reversed slot map, serves the datapath over valid/ready in
// slot order, accepts results only into slots already read, then writes the
// cache back to RAM through the inverse map. RAM traffic is paced by ram_ce.
// Assumes RAM read data is valid in the same cycle as the address.
module fft_frame_cache #(
    parameter int DW     = 32,
    parameter int LG_MAX = 6,
    parameter int CFG_W  = 4,
    localparam int PW    = LG_MAX + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CFG_W-1:0] cfg,
    output logic          err,
    output logic          dir,
    output logic          done,
    input  logic          ram_ce,
    output logic          ram_en,
    output logic          ram_we,
    output logic [PW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [DW-1:0] rd_re,
    output logic [DW-1:0] rd_im,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [DW-1:0] wr_re,
    input  logic [DW-1:0] wr_im
);
    import fftc_pkg::*;

    fftc_state_t       state;
    logic [2:0]        lg_q;
    logic              dir_q, err_q;
    logic [PW-1:0]     rd_ptr, wr_ptr, len;
    logic              cfg_legal, cfg_inv;
    logic [2:0]        cfg_lg;
    logic              agu_run, agu_part, agu_last;
    logic [PW-1:0]     agu_word;
    logic [LG_MAX-1:0] agu_slot;
    logic              pf_wr, rd_fire, wr_fire;
    logic [1:0]        c_we;
    logic [LG_MAX-1:0] c_waddr;
    logic [1:0][DW-1:0] c_wdata, c_qa, c_qb;

    fftc_cfg_decode #(.CFG_W(CFG_W), .LG_MAX(LG_MAX)) u_dec (
        .cfg(cfg), .legal(cfg_legal), .lg(cfg_lg), .inv(cfg_inv)
    );

    fftc_agu #(.LG_MAX(LG_MAX)) u_agu (
        .clk(clk), .rst_n(rst_n), .run(agu_run), .step(ram_ce), .lg(lg_q),
        .word(agu_word), .slot(agu_slot), .part(agu_part), .last(agu_last)
    );

    fftc_cache_buf #(.DW(DW), .AW(LG_MAX)) u_buf (
        .clk(clk), .we(c_we), .waddr(c_waddr), .wdata(c_wdata),
        .ra(rd_ptr[LG_MAX-1:0]), .rb(agu_slot), .qa(c_qa), .qb(c_qb)
    );

    // Handshakes, RAM strobes and cache write muxing.
    always_comb begin
        len       = PW'(1) << lg_q;
        agu_run   = (state == ST_PREFETCH) || (state == ST_WBACK);
        ram_en    = agu_run && ram_ce;
        ram_we    = (state == ST_WBACK) && ram_ce;
        ram_addr  = agu_word;
        ram_wdata = agu_part ? c_qb[1] : c_qb[0];
        rd_valid  = (state == ST_RUN) && (rd_ptr < len);
        wr_ready  = (state == ST_RUN) && (wr_ptr < rd_ptr);
        rd_fire   = rd_valid && rd_ready;
        wr_fire   = wr_valid && wr_ready;
        pf_wr     = (state == ST_PREFETCH) && ram_ce;
        c_we      = {(pf_wr && agu_part) || wr_fire, (pf_wr && !agu_part) || wr_fire};
        c_waddr   = pf_wr ? agu_slot : wr_ptr[LG_MAX-1:0];
        c_wdata   = pf_wr ? {ram_rdata, ram_rdata} : {wr_im, wr_re};
        rd_re     = c_qa[0];
        rd_im     = c_qa[1];
        done      = (state == ST_DONE);
        dir       = dir_q;
        err       = err_q;
    end

    // Frame sequencer: accepts starts, tracks read and write positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            lg_q   <= 3'd1;
            dir_q  <= 1'b0;
            err_q  <= 1'b0;
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    rd_ptr <= '0;
                    wr_ptr <= '0;
                    if (start) begin
                        if (cfg_legal) begin
                            state <= ST_PREFETCH;
                            lg_q  <= cfg_lg;
                            dir_q <= cfg_inv;
                            err_q <= 1'b0;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_PREFETCH: if (ram_ce && agu_last) state <= ST_RUN;
                ST_RUN: begin
                    if (rd_fire) rd_ptr <= rd_ptr + PW'(1);
                    if (wr_fire) begin
                        wr_ptr <= wr_ptr + PW'(1);
                        if (wr_ptr == len - PW'(1)) state <= ST_WBACK;
                    end
                end
                ST_WBACK: if (ram_ce && agu_last) state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fft_frame_cache_chk.sv
// Port-level property checker for fft_frame_cache, attached by bind.
module fft_frame_cache_chk #(
    parameter int DW     = 32,
    parameter int LG_MAX = 6,
    parameter int CFG_W  = 4,
    localparam int PW    = LG_MAX + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [CFG_W-1:0] cfg,
    input logic          err,
    input logic          dir,
    input logic          done,
    input logic          ram_ce,
    input logic          ram_en,
    input logic          ram_we,
    input logic [PW-1:0] ram_addr,
    input logic [DW-1:0] ram_wdata,
    input logic [DW-1:0] ram_rdata,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [DW-1:0] rd_re,
    input logic [DW-1:0] rd_im,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [DW-1:0] wr_re,
    input logic [DW-1:0] wr_im
);
    // No RAM traffic without the pacing strobe.
    assert_ram_paced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_ce |-> !ram_en);

    // Writes are a subset of RAM accesses.
    assert_write_in_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_en);

    // The done pulse lasts one cycle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A stalled read offer holds its data.
    assert_read_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_re) && $stable(rd_im)));

    // Datapath is never served while the RAM side is moving the frame.
    assert_no_serve_during_ram_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> (!rd_valid && !wr_ready));

    // An illegal start leaves the RAM untouched.
    assert_err_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!ram_en && !done));

    // Direction changes only at a start.
    assert_dir_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(dir));
endmodule

bind fft_frame_cache fft_frame_cache_chk #(.DW(DW), .LG_MAX(LG_MAX), .CFG_W(CFG_W)) u_chk (.*);

// File: tb/fft_frame_cache_tb.sv
module fft_frame_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int LG_MAX = 6;
    localparam int PW = LG_MAX + 1;

    // cfg[11:8], ram_ce period[7:4], ready pattern[3:0]
    localparam logic [11:0] VEC [5] = '{
        {4'b0011, 4'd1, 4'b1111},
        {4'b1110, 4'd3, 4'b1011},
        {4'b1001, 4'd2, 4'b0101},
        {4'b0100, 4'd1, 4'b0110},
        {4'b0101, 4'd1, 4'b1101}
    };

    logic clk = 0, rst_n = 0, start = 0;
    logic [3:0] cfg = '0;
    logic err, dir, done, ram_ce = 0, ram_en, ram_we;
    logic [PW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata, ram_rdata, rd_re, rd_im, wr_re = '0, wr_im = '0;
    logic rd_valid, rd_ready = 0, wr_valid = 0, wr_ready;
    logic [DW-1:0] ram_mem [2**PW];
    logic [DW-1:0] orig [2**PW];
    int checks = 0, errors = 0;

    assign ram_rdata = ram_mem[ram_addr];

    fft_frame_cache u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg), .err(err), .dir(dir),
        .done(done), .ram_ce(ram_ce), .ram_en(ram_en), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_re(rd_re), .rd_im(rd_im),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_re(wr_re), .wr_im(wr_im)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int brev(input int v, input int lg);
        int r = 0;
        for (int b = 0; b < lg; b++) if ((v >> b) & 1) r |= 1 << (lg - 1 - b);
        return r;
    endfunction

    function automatic logic [DW-1:0] res_re(input int f, input int k);
        return 32'hC0DE_0000 | DW'(f << 8) | DW'(k);
    endfunction

    function automatic logic [DW-1:0] res_im(input int f, input int k);
        return 32'h5EED_0000 ^ DW'(k * 7 + f);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input int f, input logic [3:0] c, input int ceper, input logic [3:0] mask);
        int lg = int'(c[2:0]);
        int len = 1 << lg;
        int nrd = 0, nwr = 0, nram_rd = 0, nram_wr = 0;
        bit seen = 0, poke, bad_ord = 0, bad_gate = 0, bad_data = 0;
        poke = (lg == 6);
        for (int w = 0; w < 2**PW; w++) begin
            ram_mem[w] = {4'(f), 12'hA5C, 16'(w * 37)};
            orig[w] = ram_mem[w];
        end
        @(negedge clk); start = 1; cfg = c;
        @(negedge clk); start = 0;
        for (int cyc = 0; cyc < 20000 && !seen; cyc++) begin
            ram_ce   = (cyc % ceper) == 0;
            rd_ready = mask[cyc % 4];
            wr_valid = (nwr < nrd) && mask[(cyc + 1) % 4];
            wr_re    = res_re(f, nwr);
            wr_im    = res_im(f, nwr);
            start    = poke && (cyc == 40);         // R9: start in mid-frame
            cfg      = (poke && cyc == 40) ? {~c[3], 3'd1} : c;
            #1;
            if (ram_en && !ram_we) begin
                if (int'(ram_addr) != nram_rd) bad_ord = 1;
                nram_rd++;
            end
            if (ram_we) begin
                if (int'(ram_addr) != nram_wr) bad_ord = 1;
                ram_mem[ram_addr] = ram_wdata;
                nram_wr++;
            end
            if (wr_ready && !(nwr < nrd)) bad_gate = 1;
            if (rd_valid && rd_ready) begin
                int s = brev(nrd, lg);
                check(nram_rd == 2 * len, "R5 prefetch complete before serve", 64'(nram_rd), 64'(2 * len));
                if (rd_re !== orig[2 * s] || rd_im !== orig[2 * s + 1]) begin
                    bad_data = 1;
                    $display("FAIL R5: read %0d actual %0h/%0h expected %0h/%0h",
                             nrd, rd_re, rd_im, orig[2 * s], orig[2 * s + 1]);
                end
                nrd++;
            end
            if (wr_valid && wr_ready) nwr++;
            if (done) seen = 1;
            @(negedge clk);
        end
        start = 0; cfg = c;
        checks++; if (bad_data) errors++;
        check(seen, "R8 done seen", 64'(seen), 64'd1);
        check(!bad_ord, "R4 RAM address order", 64'(bad_ord), 64'd0);
        check(!bad_gate, "R6 wr_ready only after read", 64'(bad_gate), 64'd0);
        check(nram_rd == 2 * len, "R1 words prefetched", 64'(nram_rd), 64'(2 * len));
        check(nram_wr == 2 * len, "R1 words written back", 64'(nram_wr), 64'(2 * len));
        check(nrd == len, "R5 samples served", 64'(nrd), 64'(len));
        for (int i = 0; i < len; i++) begin
            int k = brev(i, lg);
            check(ram_mem[2 * i] === res_re(f, k), "R7 real word",
                  64'(ram_mem[2 * i]), 64'(res_re(f, k)));
            check(ram_mem[2 * i + 1] === res_im(f, k), "R7 imaginary word",
                  64'(ram_mem[2 * i + 1]), 64'(res_im(f, k)));
        end
        check(dir === c[3], poke ? "R9 dir kept over mid-frame start" : "R3 dir latched",
              64'(dir), 64'(c[3]));
        check(err === 1'b0, "R2 err cleared by legal start", 64'(err), 64'd0);
        ram_ce = 1;
        #1;
        check(!done && !ram_en && !rd_valid, "R8 one-cycle done then idle",
              64'({done, ram_en, rd_valid}), 64'd0);
    endtask

    task automatic bad_code(input logic [2:0] code, input logic expdir);
        bit quiet = 1;
        @(negedge clk); start = 1; cfg = {~expdir, code};
        @(negedge clk); start = 0; ram_ce = 1;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (ram_en || done || rd_valid || wr_ready) quiet = 0;
            @(negedge clk);
        end
        check(err === 1'b1, "R2 err on illegal code", 64'(err), 64'd1);
        check(quiet, "R2 idle after illegal code", 64'(quiet), 64'd1);
        check(dir === expdir, "R3 dir kept on rejected start", 64'(dir), 64'(expdir));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check({done, err, dir, ram_en, ram_we, rd_valid, wr_ready} == 7'b0,
              "R10 reset state", 64'({done, err, dir, ram_en, ram_we, rd_valid, wr_ready}), 64'd0);
        @(negedge clk); rst_n = 1;
        bad_code(3'd0, 1'b0);
        for (int v = 0; v < 5; v++) begin
            if (v == 4) bad_code(3'd7, 1'b0);
            run_frame(v + 1, VEC[v][11:8], int'(VEC[v][7:4]), VEC[v][3:0]);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule